// File: doc/BRIEF.md
# Paired Down-Counter PWM Generator

This block makes one pulse-width modulated output from two cooperating down-counters. The period channel runs as a repeating interval timer. Each time it expires, it reloads from its period register and raises a period interrupt. The width channel is a one-shot that is retriggered by every period interrupt. It reloads from its width register, holds the output active while it counts down, and raises its own interrupt when it reaches zero.

Counting advances only on system-clock cycles where the count enable is high, so a prescaler outside the block sets the count rate. The period register and the width register can be written at any time. Their values reach the counters only at a period event, so a write never disturbs a count that is already in progress.

A start trigger launches the pair and a stop trigger halts it. With period value P and width value W, the output period is P+1 counts and the output stays active for min(W, P+1) counts of each period.

Top module: `pwm_pair_top`

## Requirements
- R1: When start is high and stop is low, the block enters the running state, and `per_irq_o` pulses high for one cycle on the following clock cycle. At that same event the period counter loads the period register and the width counter loads the width register.
- R2: While running with the count enable held high, `per_irq_o` pulses once every P+1 clock cycles, where P is the period value loaded at the previous period event.
- R3: Neither counter advances on a cycle where `cnt_en_i` is low, so every interval is measured in enabled cycles only.
- R4: With 0 < W < P+1, `pwm_o` goes high in the same cycle as the `per_irq_o` pulse and stays high for W enabled cycles. `wid_irq_o` pulses in the first cycle in which `pwm_o` is low again.
- R5: With W = 0, `pwm_o` stays low for the whole period and `wid_irq_o` never pulses.
- R6: With W ≥ P+1, `pwm_o` stays high for the whole period, including the case where W is larger than P+1, and `wid_irq_o` never pulses.
- R7: A write to the period or width register while running leaves the current period and the current pulse unchanged. The new value takes effect at the next period event.
- R8: After a stop, `pwm_o` is low from the next cycle on, and neither interrupt pulses until the next start.
- R9: If start and stop are high in the same cycle, stop wins. The block stays stopped, and no interrupt or output pulse follows.
- R10: After reset, `pwm_o`, `per_irq_o` and `wid_irq_o` are low, the block is stopped, and both data registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Count enable; counters advance only when high |
| start_i | input | 1 | Start trigger |
| stop_i | input | 1 | Stop trigger; has priority over start |
| per_we_i | input | 1 | Period register write strobe |
| per_wdata_i | input | CNT_W | Period register write data (P) |
| wid_we_i | input | 1 | Width register write strobe |
| wid_wdata_i | input | CNT_W | Width register write data (W) |
| per_irq_o | output | 1 | Period event pulse |
| wid_irq_o | output | 1 | Width expiry pulse |
| pwm_o | output | 1 | PWM output, active high |

## Verification
The bench builds the block with CNT_W = 8. This makes the full-scale period of 256 counts short enough to measure within a few hundred cycles, and it also makes width values larger than P+1 easy to reach. A behavioural model counts enabled cycles since each period event and is compared with all three outputs on every clock. Separate measurements of high time and period over several periods cover 0%, exactly 100%, over-range widths, a full-scale period, writes in the middle of a period, and counting with an irregular enable.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
    typedef enum logic {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;
endpackage

// File: rtl/pwm_period_chan.sv
module pwm_period_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             evt_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } per_st_t;

    per_st_t st_d, st_q;
    logic    advance;

    always_comb begin
        advance = run_i & tick_i & ~stop_i;
        evt_o   = start_i | (advance & (st_q.cnt == '0));
        st_d    = st_q;
        st_d.irq = evt_o;
        if (evt_o) begin
            st_d.cnt = reload_i;
        end else if (advance) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    AST_PER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !start_i) |=> $stable(st_q.cnt)); // R3
endmodule

// File: rtl/pwm_width_chan.sv
module pwm_width_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             pwm_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             pwm;
        logic             irq;
    } wid_st_t;

    wid_st_t st_d, st_q;
    logic    nonzero;

    always_comb begin
        nonzero  = (width_i != '0);
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (stop_i) begin
            st_d.busy = 1'b0;
            st_d.pwm  = 1'b0;
        end else if (load_i) begin
            st_d.cnt  = width_i;
            st_d.busy = nonzero;
            st_d.pwm  = nonzero;
        end else if (tick_i && st_q.busy) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.cnt  = '0;
                st_d.busy = 1'b0;
                st_d.pwm  = 1'b0;
                st_d.irq  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = st_q.pwm;
    assign irq_o = st_q.irq;

    AST_ZERO_WIDTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !stop_i && width_i == '0) |=> !st_q.pwm); // R5
    AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.pwm) |-> (st_q.irq || $past(stop_i))); // R4
    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !st_q.pwm); // R8
endmodule

// File: rtl/pwm_pair_top.sv
module pwm_pair_top
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             per_we_i,
    input  logic [CNT_W-1:0] per_wdata_i,
    input  logic             wid_we_i,
    input  logic [CNT_W-1:0] wid_wdata_i,
    output logic             per_irq_o,
    output logic             wid_irq_o,
    output logic             pwm_o
);
    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] wid;
        run_state_e       run;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    start_ok;
    logic    per_evt;

    always_comb begin
        start_ok = start_i & ~stop_i;
        st_d     = st_q;
        if (stop_i)        st_d.run = RUN_IDLE;
        else if (start_ok) st_d.run = RUN_ACTIVE;
        if (per_we_i) st_d.per = per_wdata_i;
        if (wid_we_i) st_d.wid = wid_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.run <= RUN_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    pwm_period_chan #(.CNT_W(CNT_W)) u_per (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (st_q.run == RUN_ACTIVE),
        .start_i  (start_ok),
        .stop_i   (stop_i),
        .tick_i   (cnt_en_i),
        .reload_i (st_q.per),
        .evt_o    (per_evt),
        .irq_o    (per_irq_o)
    );

    pwm_width_chan #(.CNT_W(CNT_W)) u_wid (
        .clk     (clk),
        .rst_n   (rst_n),
        .stop_i  (stop_i),
        .tick_i  (cnt_en_i),
        .load_i  (per_evt),
        .width_i (st_q.wid),
        .pwm_o   (pwm_o),
        .irq_o   (wid_irq_o)
    );

    AST_START_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> per_irq_o); // R1
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && stop_i) |=> (!per_irq_o && !pwm_o)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run == RUN_IDLE && !start_ok) |=> (!per_irq_o && !wid_irq_o)); // R8
endmodule

// File: tb/tb_pwm_pair_top.sv
module tb_pwm_pair_top;
    localparam int CW = 8;

    logic clk = 0, rst_n = 0, cnt_en = 1, start = 0, stop = 0;
    logic per_we = 0, wid_we = 0;
    logic [CW-1:0] per_wd = '0, wid_wd = '0;
    logic per_irq, wid_irq, pwm;

    pwm_pair_top #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en), .start_i(start), .stop_i(stop),
        .per_we_i(per_we), .per_wdata_i(per_wd), .wid_we_i(wid_we), .wid_wdata_i(wid_wd),
        .per_irq_o(per_irq), .wid_irq_o(wid_irq), .pwm_o(pwm)
    );

    always #4 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    string cur_req = "R10";
    bit en_rand = 0;
    logic [7:0] lfsr = 8'hA5;

    // behavioural reference: counts enabled cycles since the last period event
    bit m_run = 0, sdone = 1, e_pwm = 0, e_mirq = 0, e_sirq = 0;
    int k = 0, plat = 0, wlat = 0, reg_per = 0, reg_wid = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin : ref_model
        bit sa, evt;
        if (!rst_n) begin
            m_run = 0; sdone = 1; e_pwm = 0; e_mirq = 0; e_sirq = 0;
            k = 0; plat = 0; wlat = 0; reg_per = 0; reg_wid = 0;
        end else begin
            sa  = start && !stop;
            evt = sa || (m_run && cnt_en && !stop && k == plat);
            e_mirq = 0; e_sirq = 0;
            if (stop) begin
                m_run = 0; e_pwm = 0; sdone = 1;
            end else if (evt) begin
                m_run = 1; plat = reg_per; wlat = reg_wid; k = 0;
                e_mirq = 1; e_pwm = (wlat > 0); sdone = (wlat == 0);
            end else if (m_run && cnt_en) begin
                k++;
                if (!sdone && k == wlat) begin
                    e_pwm = 0; e_sirq = 1; sdone = 1;
                end
            end
            if (per_we) reg_per = int'(per_wd);
            if (wid_we) reg_wid = int'(wid_wd);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(pwm === e_pwm, cur_req, "pwm_o", int'(pwm), int'(e_pwm));
            chk(per_irq === e_mirq, cur_req, "per_irq_o", int'(per_irq), int'(e_mirq));
            chk(wid_irq === e_sirq, cur_req, "wid_irq_o", int'(wid_irq), int'(e_sirq));
        end
        lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        cnt_en <= en_rand ? lfsr[0] : 1'b1;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic write_regs(int p, int w);
        per_wd = CW'(p); wid_wd = CW'(w); per_we = 1; wid_we = 1;
        @(negedge clk);
        per_we = 0; wid_we = 0;
    endtask

    task automatic pulse_start();
        start = 1; @(negedge clk); start = 0;
    endtask

    task automatic wait_irq();
        do @(negedge clk); while (!per_irq);
    endtask

    task automatic measure(int n, int p, int w, string req);
        int total = 0, high = 0, sirq = 0;
        wait_irq(); wait_irq();
        for (int i = 0; i < n; i++) begin
            do begin
                total++;
                if (pwm) high++;
                if (wid_irq) sirq++;
                @(negedge clk);
            end while (!per_irq);
        end
        chk(total == n * (p + 1), req, "period cycles", total, n * (p + 1));
        chk(high == n * ((w < p + 1) ? w : p + 1), req, "high cycles", high,
            n * ((w < p + 1) ? w : p + 1));
        chk(sirq == n * ((w > 0 && w < p + 1) ? 1 : 0), req, "width irqs", sirq,
            n * ((w > 0 && w < p + 1) ? 1 : 0));
    endtask

    initial begin
        int gap, seen;
        repeat (3) @(negedge clk);
        chk(pwm === 0 && per_irq === 0 && wid_irq === 0, "R10", "outputs in reset",
            int'({pwm, per_irq, wid_irq}), 0);
        rst_n = 1;
        @(negedge clk);
        chk(pwm === 0 && per_irq === 0, "R10", "outputs after reset", int'({pwm, per_irq}), 0);

        // R1 start
        write_regs(9, 3);
        cur_req = "R1";
        pulse_start();
        chk(per_irq === 1, "R1", "irq after start", int'(per_irq), 1);

        // R2 and R4 period and width
        cur_req = "R2";
        measure(3, 9, 3, "R2");
        cur_req = "R4";
        measure(2, 9, 3, "R4");

        // R7 writes straddling a period event
        cur_req = "R7";
        wait_irq();
        write_regs(4, 2);
        gap = 1;
        while (!per_irq) begin gap++; @(negedge clk); end
        chk(gap == 10, "R7", "period after write", gap, 10);
        measure(2, 4, 2, "R7");

        // R3 irregular enable
        cur_req = "R3";
        write_regs(6, 2);
        en_rand = 1;
        repeat (300) @(negedge clk);
        en_rand = 0;
        repeat (2) @(negedge clk);

        // R5 zero width
        cur_req = "R5";
        write_regs(4, 0);
        measure(2, 4, 0, "R5");

        // R6 full and over-range width
        cur_req = "R6";
        write_regs(4, 5);
        measure(2, 4, 5, "R6");
        write_regs(4, 200);
        measure(2, 4, 200, "R6");

        // full-scale period
        cur_req = "R2";
        write_regs(255, 128);
        measure(1, 255, 128, "R2");

        // R8 stop
        cur_req = "R8";
        write_regs(7, 3);
        stop = 1; @(negedge clk); stop = 0;
        chk(pwm === 0, "R8", "pwm after stop", int'(pwm), 0);
        seen = 0;
        repeat (20) begin
            if (per_irq || wid_irq || pwm) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R8", "activity while stopped", seen, 0);

        // R9 stop wins over start
        cur_req = "R9";
        start = 1; stop = 1; @(negedge clk); start = 0; stop = 0;
        seen = 0;
        repeat (12) begin
            if (per_irq || wid_irq || pwm) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R9", "activity after simultaneous triggers", seen, 0);

        // restart resumes with stored values
        cur_req = "R1";
        pulse_start();
        chk(per_irq === 1 && pwm === 1, "R1", "restart irq and pwm", int'({per_irq, pwm}), 3);
        measure(2, 7, 3, "R4");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule